// File: doc/BRIEF.md
# Timer Compare Event Unit

This block watches a free-running timer. Each cycle it compares the timer value with a compare value. When the two become equal, it carries out the action chosen by a 4-bit mode field. The available actions are:

- toggle an output pin;
- preset the pin on mode entry and drive it to the opposite level on a match;
- raise an interrupt flag while leaving the pin to general-purpose logic;
- issue a special event, which resets the timer and starts an analog conversion.

The timer and the converter are outside the block. They receive the single-cycle pulses the block produces.

Every output is registered. A match is seen only on the first cycle of equality, so a stalled timer cannot trigger repeated events. The cycle in which the mode field changes is treated as an entry cycle. In that cycle the preset modes load their initial pin level and no match is acted on.

Top module: `cmp_event_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pin_out, pin_oe, irq_flag, timer_rst and conv_start are all 0.
- R2: A match is the first sampled cycle where timer_val equals compare_val, following a cycle where they differed. Its effects appear after that clock edge. Holding equality on later cycles produces no further events.
- R3: Mode 4'b0010 drives pin_oe high, inverts pin_out on each match and sets irq_flag.
- R4: On entry to mode 4'b1000, pin_out becomes 0. A later match drives it to 1 and sets irq_flag. pin_oe is 1.
- R5: On entry to mode 4'b1001, pin_out becomes 1. A later match drives it to 0 and sets irq_flag. pin_oe is 1.
- R6: Mode 4'b1010 holds pin_oe at 0. A match sets irq_flag and leaves pin_out unchanged.
- R7: In mode 4'b1011 a match makes timer_rst and conv_start both 1 for exactly one cycle and sets irq_flag. pin_out is unchanged and pin_oe is 1.
- R8: Reserved modes 4'b0001 and 4'b0011, and every code not named in R3 to R7 or R9, take no action on a match. irq_flag, pin_out, timer_rst and conv_start keep their values or stay 0, and pin_oe is 0.
- R9: Mode 4'b0000 clears pin_out and irq_flag and holds pin_oe at 0.
- R10: A flag_clr pulse clears irq_flag on the next edge. If a flag-setting match occurs in the same cycle, the flag ends up set.
- R11: A match in the cycle where mode differs from its value in the previous cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timer_val | input | 16 | Current timer count |
| compare_val | input | 16 | Compare value |
| mode | input | 4 | Action select |
| flag_clr | input | 1 | Clears the interrupt flag |
| pin_out | output | 1 | Pin level |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Interrupt flag |
| timer_rst | output | 1 | One-cycle timer reset pulse |
| conv_start | output | 1 | One-cycle conversion start pulse |

## Verification
Each output changes one edge after its cause is sampled. This applies to a new mode code, the first cycle of equality and a flag_clr strobe. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. The one-cycle pulses are read on that falling edge and again one cycle later, to confirm they have returned to 0. Mode changes and matches are kept on separate cycles, except in the test that deliberately merges them to exercise the entry-cycle rule.

// File: rtl/cmp_event_pkg.sv
package cmp_event_pkg;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MD_OFF    = 4'b0000;
    localparam logic [MODE_W-1:0] MD_TOGGLE = 4'b0010;
    localparam logic [MODE_W-1:0] MD_SETHI  = 4'b1000;
    localparam logic [MODE_W-1:0] MD_SETLO  = 4'b1001;
    localparam logic [MODE_W-1:0] MD_FLAG   = 4'b1010;
    localparam logic [MODE_W-1:0] MD_SPEC   = 4'b1011;

    typedef struct packed {
        logic drive_pin;
        logic raise_flag;
        logic toggle;
        logic force_hi;
        logic force_lo;
        logic init_en;
        logic init_lvl;
        logic special;
        logic off;
    } act_t;

    typedef struct packed {
        logic              pin;
        logic              oe;
        logic              flag;
        logic              trst;
        logic              conv;
        logic [MODE_W-1:0] mode_prev;
    } st_t;
endpackage

// File: rtl/cmp_match_detect.sv
module cmp_match_detect #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic [TW-1:0] compare_val,
    output logic          hit
);
    logic eq, eq_d, eq_q;

    always_comb begin
        eq   = (timer_val == compare_val);
        eq_d = eq;
        hit  = eq & ~eq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_d;
    end
endmodule

// File: rtl/cmp_mode_decode.sv
module cmp_mode_decode
    import cmp_event_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output act_t              act
);
    always_comb begin
        act = '0;
        case (mode)
            MD_OFF: act.off = 1'b1;
            MD_TOGGLE: begin
                act.drive_pin  = 1'b1;
                act.raise_flag = 1'b1;
                act.toggle     = 1'b1;
            end
            MD_SETHI: begin
                act.drive_pin  = 1'b1;
                act.raise_flag = 1'b1;
                act.force_hi   = 1'b1;
                act.init_en    = 1'b1;
                act.init_lvl   = 1'b0;
            end
            MD_SETLO: begin
                act.drive_pin  = 1'b1;
                act.raise_flag = 1'b1;
                act.force_lo   = 1'b1;
                act.init_en    = 1'b1;
                act.init_lvl   = 1'b1;
            end
            MD_FLAG: act.raise_flag = 1'b1;
            MD_SPEC: begin
                act.drive_pin  = 1'b1;
                act.raise_flag = 1'b1;
                act.special    = 1'b1;
            end
            default: act = '0;
        endcase
    end
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
    import cmp_event_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     timer_val,
    input  logic [TW-1:0]     compare_val,
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_clr,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq_flag,
    output logic              timer_rst,
    output logic              conv_start
);
    logic hit;
    logic entry;
    act_t act;
    st_t  st_d, st_q;

    cmp_match_detect #(.TW(TW)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer_val   (timer_val),
        .compare_val (compare_val),
        .hit         (hit)
    );

    cmp_mode_decode u_dec (
        .mode (mode),
        .act  (act)
    );

    always_comb begin
        st_d           = st_q;
        st_d.trst      = 1'b0;
        st_d.conv      = 1'b0;
        st_d.mode_prev = mode;
        st_d.oe        = act.drive_pin;
        entry          = (mode != st_q.mode_prev);

        if (flag_clr) st_d.flag = 1'b0;

        if (entry) begin
            if (act.init_en) st_d.pin = act.init_lvl;
        end else if (hit) begin
            if (act.toggle)     st_d.pin  = ~st_q.pin;
            if (act.force_hi)   st_d.pin  = 1'b1;
            if (act.force_lo)   st_d.pin  = 1'b0;
            if (act.raise_flag) st_d.flag = 1'b1;
            if (act.special) begin
                st_d.trst = 1'b1;
                st_d.conv = 1'b1;
            end
        end

        if (act.off) begin
            st_d.pin  = 1'b0;
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out    = st_q.pin;
    assign pin_oe     = st_q.oe;
    assign irq_flag   = st_q.flag;
    assign timer_rst  = st_q.trst;
    assign conv_start = st_q.conv;
endmodule

// File: rtl/cmp_event_checker.sv
module cmp_event_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] timer_val,
    input logic [TW-1:0] compare_val,
    input logic [3:0]    mode,
    input logic          flag_clr,
    input logic          pin_out,
    input logic          pin_oe,
    input logic          irq_flag,
    input logic          timer_rst,
    input logic          conv_start
);
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rst |=> !timer_rst);

    assert_pulse_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rst |-> conv_start);

    assert_pulse_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 4'b1011) |=> !conv_start);

    assert_reserved_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b0001 || mode == 4'b0011) |=> !pin_oe);

    assert_reserved_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 4'b0001 || mode == 4'b0011) && !irq_flag) |=> !irq_flag);

    assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b0000) |=> (!pin_out && !irq_flag && !pin_oe));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && timer_val != compare_val) |=> !irq_flag);

    assert_flagonly_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b1010) |=> !pin_oe);
endmodule

bind cmp_event_unit cmp_event_checker #(.TW(TW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .timer_val   (timer_val),
    .compare_val (compare_val),
    .mode        (mode),
    .flag_clr    (flag_clr),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .irq_flag    (irq_flag),
    .timer_rst   (timer_rst),
    .conv_start  (conv_start)
);

// File: tb/cmp_event_unit_bench.sv
`timescale 1ns/1ps
module cmp_event_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = 16'd0;
    logic [15:0] compare_val = 16'd100;
    logic [3:0]  mode = 4'b0000;
    logic        flag_clr = 1'b0;
    logic        pin_out, pin_oe, irq_flag, timer_rst, conv_start;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_event_unit u_cmp_event_unit (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .compare_val(compare_val),
        .mode(mode), .flag_clr(flag_clr), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_flag(irq_flag), .timer_rst(timer_rst), .conv_start(conv_start)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mode(logic [3:0] m);
        timer_val = 16'd5;
        step();
        mode = m;
        step();
    endtask

    task automatic do_match();
        timer_val = 16'd5;
        step();
        timer_val = compare_val;
        step();
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "pin_out", pin_out, 1'b0);
        chk("R1", "pin_oe", pin_oe, 1'b0);
        chk("R1", "irq_flag", irq_flag, 1'b0);
        chk("R1", "timer_rst", timer_rst, 1'b0);
        chk("R1", "conv_start", conv_start, 1'b0);
    endtask

    task automatic t_toggle();
        set_mode(4'b0010);
        chk("R3", "oe after entry", pin_oe, 1'b1);
        chk("R3", "pin after entry", pin_out, 1'b0);
        do_match();
        chk("R3", "pin after match", pin_out, 1'b1);
        chk("R3", "flag after match", irq_flag, 1'b1);
        step();
        chk("R2", "pin with held equality", pin_out, 1'b1);
        step();
        chk("R2", "pin with held equality 2", pin_out, 1'b1);
        do_match();
        chk("R3", "pin after second match", pin_out, 1'b0);
        do_match();
        chk("R3", "pin after third match", pin_out, 1'b1);
        clear_flag();
        chk("R10", "flag cleared", irq_flag, 1'b0);
    endtask

    task automatic t_set_high();
        set_mode(4'b1000);
        chk("R4", "init low on entry", pin_out, 1'b0);
        chk("R4", "oe", pin_oe, 1'b1);
        chk("R4", "flag not set by entry", irq_flag, 1'b0);
        do_match();
        chk("R4", "pin high on match", pin_out, 1'b1);
        chk("R4", "flag on match", irq_flag, 1'b1);
        timer_val = 16'd5;
        step();
        timer_val = compare_val;
        flag_clr  = 1'b1;
        step();
        flag_clr  = 1'b0;
        chk("R10", "set beats clear", irq_flag, 1'b1);
        clear_flag();
        chk("R10", "clear alone", irq_flag, 1'b0);
    endtask

    task automatic t_set_low();
        set_mode(4'b1001);
        chk("R5", "init high on entry", pin_out, 1'b1);
        chk("R5", "oe", pin_oe, 1'b1);
        do_match();
        chk("R5", "pin low on match", pin_out, 1'b0);
        chk("R5", "flag on match", irq_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_entry_match();
        timer_val = 16'd5;
        step();
        mode = 4'b1010;
        timer_val = compare_val;
        step();
        chk("R11", "match in entry cycle ignored", irq_flag, 1'b0);
        chk("R6", "oe released", pin_oe, 1'b0);
    endtask

    task automatic t_flag_only();
        do_match();
        chk("R6", "flag on match", irq_flag, 1'b1);
        chk("R6", "pin unchanged", pin_out, 1'b0);
        chk("R6", "oe low", pin_oe, 1'b0);
        clear_flag();
    endtask

    task automatic t_special();
        set_mode(4'b1011);
        chk("R7", "oe", pin_oe, 1'b1);
        do_match();
        chk("R7", "timer_rst pulse", timer_rst, 1'b1);
        chk("R7", "conv_start pulse", conv_start, 1'b1);
        chk("R7", "flag", irq_flag, 1'b1);
        chk("R7", "pin unchanged", pin_out, 1'b0);
        step();
        chk("R7", "timer_rst ends", timer_rst, 1'b0);
        chk("R7", "conv_start ends", conv_start, 1'b0);
        clear_flag();
    endtask

    task automatic t_reserved(logic [3:0] m);
        set_mode(4'b1001);
        set_mode(m);
        chk("R8", "oe low", pin_oe, 1'b0);
        do_match();
        chk("R8", "no flag", irq_flag, 1'b0);
        chk("R8", "pin held", pin_out, 1'b1);
        chk("R8", "no timer_rst", timer_rst, 1'b0);
        chk("R8", "no conv_start", conv_start, 1'b0);
    endtask

    task automatic t_off();
        set_mode(4'b1010);
        do_match();
        chk("R9", "flag before off", irq_flag, 1'b1);
        mode = 4'b0000;
        step();
        chk("R9", "pin cleared", pin_out, 1'b0);
        chk("R9", "flag cleared", irq_flag, 1'b0);
        chk("R9", "oe low", pin_oe, 1'b0);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_toggle();
        t_set_high();
        t_set_low();
        t_entry_match();
        t_flag_only();
        t_special();
        t_reserved(4'b0001);
        t_reserved(4'b0011);
        t_reserved(4'b0110);
        t_off();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule